// File: doc/BRIEF.md
# Cascadable Preset Counter Stage

This block is one stage of a synchronous up-counter, 4 bits wide by default. It can be loaded in parallel, cleared by an active-low reset, and enabled by two separate count-enable levels. The state moves on the rising clock edge. The stage takes one of four actions, in strict priority order: reset, load, count, hold. The stage counts only when both enables are high. Only the chain enable gates the terminal-count flag.

The terminal-count flag is combinational. It is high when the chain enable is high and the state sits at the last value of the sequence. To build a wider counter, feed each stage's flag into the chain enable of the next stage. All stages share the clock, the load strobe, the preset bus slices and the plain count enable. The chain then counts as one wide binary number with no glue logic.

Two parameters pick the variant:
- `ASYNC_RST` selects an immediate clear or a clear at the clock edge.
- `DECADE` selects a binary sequence or a 0 to 9 sequence. A decade stage needs `WIDTH` of at least 4.

No data stream passes through the block, so there is no valid/ready handshake and no back-pressure. Every pin is a plain level, sampled at the rising clock edge or, for the asynchronous clear, acting at once.

Top module: `preset_counter_stage`

## Requirements
- R1: With `ASYNC_RST`=1, driving `rst_n` low forces `q` to 0 at once, before any clock edge, and holds it at 0 while `rst_n` stays low.
- R2: With `ASYNC_RST`=0, driving `rst_n` low leaves `q` unchanged until the next rising edge, where `q` becomes 0.
- R3: Reset wins over the load strobe and over both enables. If `rst_n` is low at an edge, `q` is 0 after that edge whatever `load_n`, `preset_d`, `cnt_enable` and `carry_in` are.
- R4: If `rst_n` is high and `load_n` is low at a rising edge, `q` takes the value of `preset_d` after that edge. This happens whatever the enable levels are, including during counting.
- R5: If `rst_n` and `load_n` are high and both `cnt_enable` and `carry_in` are high, `q` advances by one step at each rising edge.
- R6: If `rst_n` and `load_n` are high and either enable is low, `q` keeps its value across the edge.
- R7: `term_cnt` is 1 exactly when `carry_in` is 1 and `q` equals the last value of the sequence. The last value is 15 in binary mode and 9 in decade mode. `cnt_enable` has no influence on `term_cnt`.
- R8: In binary mode the state wraps from 15 to 0. For example, a preset of 12 followed by six counts gives 13, 14, 15, 0, 1, 2.
- R9: In decade mode the state runs 0 to 9, and `term_cnt` rises at 9 when `carry_in` is 1. The count after 9 is 0.
- R10: In decade mode, a state of 10 to 15 goes to 0 on its next count and holds when not counting. `term_cnt` stays 0 in such a state.
- R11: A chain of stages, with each `term_cnt` driving the next `carry_in`, counts as a single binary counter `WIDTH` times the number of stages wide. The last stage's `term_cnt` is high at all ones when the first `carry_in` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low clear; immediate or edge-timed per `ASYNC_RST` |
| load_n | input | 1 | Active-low parallel load strobe |
| preset_d | input | WIDTH | Value loaded while `load_n` is low |
| cnt_enable | input | 1 | Count enable that does not touch `term_cnt` |
| carry_in | input | 1 | Chain enable; also gates `term_cnt` |
| q | output | WIDTH | Counter state |
| term_cnt | output | 1 | Terminal-count flag for the next stage |

## Verification
The state register drives `q` directly, so a wrong next-state value shows on the ports right after the edge that stored it. A corrupted wrap or a missed illegal-state recovery shows at the first count out of the last or illegal value. A stage that miscomputes its flag shows up one edge later in a chain: the next stage either fails to step or steps early, and the combined value departs from a reference integer. Reset priority faults appear at the first edge where reset and load overlap.

// File: rtl/ctr_pkg.sv
package ctr_pkg;
  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_COUNT = 2'd1,
    OP_LOAD  = 2'd2
  } ctr_op_e;
endpackage

// File: rtl/ctr_op_decode.sv
module ctr_op_decode
  import ctr_pkg::*;
(
  input  logic    load_n,
  input  logic    cnt_enable,
  input  logic    carry_in,
  output ctr_op_e op
);
  // load beats count, count beats hold; reset is applied in the register
  always_comb begin
    if (!load_n)                      op = OP_LOAD;
    else if (cnt_enable && carry_in)  op = OP_COUNT;
    else                              op = OP_HOLD;
  end
endmodule

// File: rtl/ctr_next_calc.sv
module ctr_next_calc
  import ctr_pkg::*;
#(
  parameter int unsigned          WIDTH = 4,
  parameter logic [WIDTH-1:0]     LAST  = '1
)(
  input  ctr_op_e          op,
  input  logic [WIDTH-1:0] cur,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] nxt
);
  logic             at_or_past_end;
  logic [WIDTH-1:0] stepped;

  // one compare covers the normal wrap and recovery from out-of-range states
  assign at_or_past_end = (cur >= LAST);
  assign stepped        = at_or_past_end ? '0 : cur + 1'b1;

  always_comb begin
    unique case (op)
      OP_LOAD:  nxt = din;
      OP_COUNT: nxt = stepped;
      default:  nxt = cur;
    endcase
  end
endmodule

// File: rtl/ctr_state_reg.sv
module ctr_state_reg #(
  parameter int unsigned WIDTH     = 4,
  parameter bit          ASYNC_RST = 1'b1
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] nxt,
  output logic [WIDTH-1:0] q
);
  generate
    if (ASYNC_RST) begin : g_async
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= nxt;
      end
    end else begin : g_sync
      always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= nxt;
      end
    end
  endgenerate
endmodule

// File: rtl/ctr_tc_gen.sv
module ctr_tc_gen #(
  parameter int unsigned      WIDTH = 4,
  parameter logic [WIDTH-1:0] LAST  = '1
)(
  input  logic [WIDTH-1:0] q,
  input  logic             carry_in,
  output logic             term_cnt
);
  // combinational so a chain settles within one clock period
  assign term_cnt = carry_in && (q == LAST);
endmodule

// File: rtl/preset_counter_stage.sv
module preset_counter_stage
  import ctr_pkg::*;
#(
  parameter int unsigned WIDTH     = 4,
  parameter bit          DECADE    = 1'b0,
  parameter bit          ASYNC_RST = 1'b1
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_n,
  input  logic [WIDTH-1:0] preset_d,
  input  logic             cnt_enable,
  input  logic             carry_in,
  output logic [WIDTH-1:0] q,
  output logic             term_cnt
);
  localparam logic [WIDTH-1:0] LAST = DECADE ? WIDTH'(9) : '1;

  ctr_op_e          op;
  logic [WIDTH-1:0] nxt;

  ctr_op_decode u_dec (
    .load_n     (load_n),
    .cnt_enable (cnt_enable),
    .carry_in   (carry_in),
    .op         (op)
  );

  ctr_next_calc #(.WIDTH(WIDTH), .LAST(LAST)) u_next (
    .op  (op),
    .cur (q),
    .din (preset_d),
    .nxt (nxt)
  );

  ctr_state_reg #(.WIDTH(WIDTH), .ASYNC_RST(ASYNC_RST)) u_reg (
    .clk   (clk),
    .rst_n (rst_n),
    .nxt   (nxt),
    .q     (q)
  );

  ctr_tc_gen #(.WIDTH(WIDTH), .LAST(LAST)) u_tc (
    .q        (q),
    .carry_in (carry_in),
    .term_cnt (term_cnt)
  );
endmodule

// File: rtl/preset_counter_stage_chk.sv
module preset_counter_stage_chk #(
  parameter int unsigned WIDTH  = 4,
  parameter bit          DECADE = 1'b0
)(
  input logic             clk,
  input logic             rst_n,
  input logic             load_n,
  input logic [WIDTH-1:0] preset_d,
  input logic             cnt_enable,
  input logic             carry_in,
  input logic [WIDTH-1:0] q,
  input logic             term_cnt
);
  localparam logic [WIDTH-1:0] LAST = DECADE ? WIDTH'(9) : '1;

  function automatic logic [WIDTH-1:0] succ(input logic [WIDTH-1:0] v);
    if (v >= LAST) return '0;
    return v + 1'b1;
  endfunction

  // R3
  reset_clears_chk: assert property (@(posedge clk)
    !rst_n |=> (q == '0));

  // R4
  load_takes_preset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_n |=> (q == $past(preset_d)));

  // R5
  count_steps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n && cnt_enable && carry_in) |=> (q == succ($past(q))));

  // R6
  hold_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n && !(cnt_enable && carry_in)) |=> $stable(q));

  // R7
  tc_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !carry_in |-> !term_cnt);

  // R7
  tc_at_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    term_cnt |-> (q == LAST));
endmodule

bind preset_counter_stage preset_counter_stage_chk #(
  .WIDTH  (WIDTH),
  .DECADE (DECADE)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .load_n     (load_n),
  .preset_d   (preset_d),
  .cnt_enable (cnt_enable),
  .carry_in   (carry_in),
  .q          (q),
  .term_cnt   (term_cnt)
);

// File: tb/preset_counter_stage_tb_top.sv
module preset_counter_stage_tb_top;
  localparam int W  = 4;
  localparam int NS = 3;
  localparam int CW = W * NS;
  localparam logic [CW-1:0] CMAX = '1;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  // binary chain, asynchronous clear
  logic          rst_a = 1'b0, load_n = 1'b1, en_p = 1'b0, chain_en = 1'b0;
  logic [CW-1:0] preset = '0;
  logic [CW-1:0] chain_q;
  logic [NS:0]   carry;
  assign carry[0] = chain_en;

  // decade stage, synchronous clear
  logic          dec_rst = 1'b0, dec_ld = 1'b1, dec_p = 1'b0, dec_t = 1'b0;
  logic [W-1:0]  dec_d = '0;
  logic [W-1:0]  dec_q;
  logic          dec_tc;

  int c_exp = 0;
  int d_exp = 0;

  preset_counter_stage #(.WIDTH(W), .DECADE(1'b0), .ASYNC_RST(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_a), .load_n(load_n), .preset_d(preset[W-1:0]),
    .cnt_enable(en_p), .carry_in(carry[0]), .q(chain_q[W-1:0]), .term_cnt(carry[1])
  );

  for (genvar i = 1; i < NS; i++) begin : g_stage
    preset_counter_stage #(.WIDTH(W), .DECADE(1'b0), .ASYNC_RST(1'b1)) stage_i (
      .clk(clk), .rst_n(rst_a), .load_n(load_n), .preset_d(preset[i*W +: W]),
      .cnt_enable(en_p), .carry_in(carry[i]), .q(chain_q[i*W +: W]), .term_cnt(carry[i+1])
    );
  end

  preset_counter_stage #(.WIDTH(W), .DECADE(1'b1), .ASYNC_RST(1'b0)) dec_i (
    .clk(clk), .rst_n(dec_rst), .load_n(dec_ld), .preset_d(dec_d),
    .cnt_enable(dec_p), .carry_in(dec_t), .q(dec_q), .term_cnt(dec_tc)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int chain_next(int v);
    if (!rst_a) return 0;
    if (!load_n) return int'(preset);
    if (en_p && chain_en) return (v + 1) % (1 << CW);
    return v;
  endfunction

  function automatic int dec_next(int v);
    if (!dec_rst) return 0;
    if (!dec_ld) return int'(dec_d);
    if (dec_p && dec_t) return (v >= 9) ? 0 : v + 1;
    return v;
  endfunction

  // one edge: model both counters, then compare just after the edge
  task automatic tick(input string force_tag = "");
    string tc_tag, td_tag;
    @(posedge clk);
    if (!rst_a)                 tc_tag = (!load_n || en_p) ? "R3" : "R1";
    else if (!load_n)           tc_tag = "R4";
    else if (en_p && chain_en)  tc_tag = "R5";
    else                        tc_tag = "R6";
    if (!dec_rst)               td_tag = "R2";
    else if (!dec_ld)           td_tag = "R4";
    else if (dec_p && dec_t)    td_tag = (d_exp > 9) ? "R10" : "R9";
    else                        td_tag = "R6";
    if (force_tag != "") begin tc_tag = force_tag; td_tag = force_tag; end
    c_exp = chain_next(c_exp);
    d_exp = dec_next(d_exp);
    #1;
    chk(tc_tag, int'(chain_q), c_exp);
    chk("R11", int'(carry[NS]), int'(chain_en && c_exp == int'(CMAX)));
    chk("R7", int'(carry[1]), int'(chain_en && (c_exp % 16) == 15));
    chk(td_tag, int'(dec_q), d_exp);
    chk("R9", int'(dec_tc), int'(dec_t && d_exp == 9));
    @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      chk("watchdog", 1, 0);
      finish_run();
    end
  end

  initial begin
    // reset state
    tick(); tick();
    chk("R1", int'(carry[NS]), 0);
    rst_a = 1'b1; dec_rst = 1'b1;

    // R8: preset 12 then six counts on the low stage
    load_n = 1'b0; preset = CW'(12); tick();
    load_n = 1'b1; en_p = 1'b1; chain_en = 1'b1;
    for (int k = 0; k < 6; k++) begin
      tick("R8");
      chk("R8", int'(chain_q[W-1:0]), (13 + k) % 16);
    end

    // R11: rollover across all stages
    load_n = 1'b0; preset = CMAX - CW'(2); tick();
    load_n = 1'b1;
    for (int k = 0; k < 4; k++) tick("R11");

    // R7: cnt_enable low does not hide the flag, carry_in low does
    load_n = 1'b0; en_p = 1'b0; preset = CMAX; tick();
    load_n = 1'b1; tick();
    chk("R7", int'(carry[NS]), 1);
    chain_en = 1'b0; #1;
    chk("R7", int'(carry[NS]), 0);
    tick();

    // R1: asynchronous clear acts before the edge
    rst_a = 1'b0; #1;
    chk("R1", int'(chain_q), 0);
    c_exp = 0;
    tick(); rst_a = 1'b1;

    // R3: reset during load with enables high
    load_n = 1'b0; preset = CW'(12'h5A5); en_p = 1'b1; chain_en = 1'b1; rst_a = 1'b0;
    dec_rst = 1'b0; dec_ld = 1'b0; dec_d = 4'd5; dec_p = 1'b1; dec_t = 1'b1;
    tick("R3");
    rst_a = 1'b1; dec_rst = 1'b1;

    // R4: load during counting
    tick(); tick();
    load_n = 1'b0; preset = CW'(12'h123); tick("R4");
    load_n = 1'b1; tick();

    // R9: decade 7 -> 8 -> 9 -> 0 -> 1
    dec_ld = 1'b0; dec_d = 4'd7; tick();
    dec_ld = 1'b1;
    for (int k = 0; k < 4; k++) tick();

    // R10: illegal states
    dec_ld = 1'b0; dec_d = 4'd12; tick();
    dec_ld = 1'b1; tick("R10");
    chk("R10", int'(dec_q), 0);
    dec_ld = 1'b0; dec_d = 4'd15; tick();
    dec_ld = 1'b1; dec_p = 1'b0; tick("R10");
    chk("R10", int'(dec_tc), 0);
    // R6: carry_in low holds
    dec_p = 1'b1; dec_t = 1'b0; tick("R6");
    dec_t = 1'b1; tick("R10");

    // R2: synchronous clear waits for the edge
    dec_ld = 1'b0; dec_d = 4'd3; tick();
    dec_ld = 1'b1; dec_p = 1'b0;
    dec_rst = 1'b0; #1;
    chk("R2", int'(dec_q), 3);
    tick("R2");
    dec_rst = 1'b1;

    // constrained random
    void'($urandom(32'd20240611));
    for (int n = 0; n < 3000; n++) begin
      rst_a    = ($urandom % 100) >= 2;
      load_n   = ($urandom % 10) != 0;
      en_p     = ($urandom % 5) != 0;
      chain_en = ($urandom % 5) != 0;
      preset   = ($urandom % 2) ? (CMAX - CW'($urandom % 8)) : CW'($urandom);
      dec_rst  = ($urandom % 100) >= 2;
      dec_ld   = ($urandom % 8) != 0;
      dec_p    = ($urandom % 5) != 0;
      dec_t    = ($urandom % 5) != 0;
      dec_d    = W'($urandom);
      if (!rst_a) begin
        #1;
        chk("R1", int'(chain_q), 0);
        c_exp = 0;
      end
      tick();
    end
    finish_run();
  end
endmodule